// File: doc/BRIEF.md
# Single-Channel DMA Transfer Sequencer

This block moves data for one DMA channel. Software programs a source address, a fixed destination address and a 16-bit transfer count, then turns the channel on. Each transfer is a read from the source followed by a write of the same data to the destination. Both moves use one memory bus with a valid/ready handshake. After each transfer the source address can go up, go down or stay where it is. The step is one byte or one word, chosen by a size bit.

A transfer can start in one of two ways. In auto mode the channel runs transfers back to back for as long as it is on. In request mode it makes one transfer for each pulse on `dreq`, and it remembers at most one pulse that arrives while a transfer is in progress.

The channel runs only when two bits are both 1: the run bit in the control register and a separate master bit. The run bit is guarded. A write of 1 takes effect only if software has first read the control register and seen run at 0. When the count runs out, the hardware clears run. If the interrupt-enable bit is set, it also raises `irq`, which stays high until the next write to the control register.

Memory bus rules:
- `mem_valid` marks a bus cycle.
- `mem_write` tells a write (1) from a read (0).
- A beat completes in a cycle where `mem_valid` and `mem_ready` are both high.
- While `mem_ready` is low, the sequencer holds `mem_addr`, `mem_write`, `mem_wide` and `mem_wdata` unchanged.
- Read data is taken from `mem_rdata` in the completing cycle.

Top module: `dmaseq_top`

## Requirements
- R1: After reset:
  - the control register reads 0 (run, size, step enable, direction, interrupt enable and auto are all 0);
  - the master bit is 0;
  - `irq` is 0;
  - `mem_valid` is 0.
- R2: A transfer starts only while control bit 0 (run) and master-register bit 0 are both 1. A `dreq` pulse that arrives while the channel is off is discarded, not remembered. Clearing master stops new transfers after the current one finishes.
- R3: A write to control offset 0 with bit 0 set sets run only if the last control-register read before it returned run=0 and no control write came in between. Otherwise that write leaves run at 0. Every control write uses up the arming.
- R4: With control bit 5 (auto) at 1, transfers begin by themselves, one after another. With bit 5 at 0, each transfer needs a `dreq` pulse: the pulse is latched at a clock edge, and the read beat starts two cycles after the pulse cycle.
- R5: In request mode, `dreq` pulses that arrive while a transfer is in progress are merged into a single pending request. That request starts one more transfer after the current one ends.
- R6: A transfer is one read beat (`mem_write`=0) at the source address. Its completion is followed in the next cycle by one write beat (`mem_write`=1) at the destination address, carrying the data that was read. Outputs stay stable while `mem_ready` is low.
- R7: Control bit 1 (size) selects the transfer width:
  - 0: byte transfer. `mem_wide`=0, and the write data is `mem_rdata[7:0]` with the upper bits zero.
  - 1: word transfer. `mem_wide`=1, and the full read data is written.
- R8: The source address changes after each write beat completes, following control bit 2 (step enable) and bit 3 (direction):
  - step enable 0: no change;
  - step enable 1, direction 0: up by 1 for a byte transfer or by 2 for a word transfer;
  - step enable 1, direction 1: down by the same amounts.

  The destination address never changes.
- R9: The counter goes down by one for each completed transfer. The write beat that brings it from 1 to 0 clears run.
- R10: When the hardware clears run and control bit 4 (interrupt enable) is 1, `irq` rises and stays high until the next write to the control register. With bit 4 at 0, `irq` stays low.
- R11: `cpu_rdata` shows the register chosen by `cpu_addr`, zero-extended:
  - 0: control;
  - 1: source;
  - 2: destination;
  - 3: count;
  - 4: master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | Register access strobe |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 3 | Register offset |
| cpu_wdata | input | REG_W | Register write data |
| cpu_rdata | output | REG_W | Register read data (combinational) |
| dreq | input | 1 | External transfer request pulse |
| mem_valid | output | 1 | Bus beat valid |
| mem_ready | input | 1 | Bus beat accepted / read data valid |
| mem_write | output | 1 | Beat direction |
| mem_wide | output | 1 | Word (1) or byte (0) beat |
| mem_addr | output | ADDR_W | Beat address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data |
| irq | output | 1 | End-of-count interrupt |

## Verification
The hardest case to reach from the ports is a merged request. It needs several `dreq` pulses to land while one transfer is still in progress, without any of them leaking into a third transfer. The stimulus creates this by holding `mem_ready` low so the read beat stalls, firing two pulses into that window, and then releasing the bus. It then checks that the source address and count moved by exactly two transfers. The guarded enable is reached by alternating control reads and writes in both orders, and the end-of-count interrupt by running the counter down in request mode with the bus answering without stalls.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;
  // Register offsets; the sequencer decodes these directly.
  localparam logic [2:0] OFS_CTRL   = 3'd0;
  localparam logic [2:0] OFS_SRC    = 3'd1;
  localparam logic [2:0] OFS_DST    = 3'd2;
  localparam logic [2:0] OFS_CNT    = 3'd3;
  localparam logic [2:0] OFS_MASTER = 3'd4;

  // Control register, run is bit 0.
  typedef struct packed {
    logic auto_go;  // bit 5
    logic irq_en;   // bit 4
    logic down;     // bit 3
    logic step_en;  // bit 2
    logic wide;     // bit 1
    logic run;      // bit 0
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_t;
endpackage

// File: rtl/dmaseq_step.sv
module dmaseq_step #(
  parameter int unsigned ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr_cur,
  input  logic              wide,
  input  logic              step_en,
  input  logic              down,
  output logic [ADDR_W-1:0] addr_next
);
  localparam logic [ADDR_W-1:0] STRIDE_BYTE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STRIDE_WORD = ADDR_W'(2);

  logic [ADDR_W-1:0] stride;

  always_comb begin
    stride = wide ? STRIDE_WORD : STRIDE_BYTE;
    if (!step_en)  addr_next = addr_cur;
    else if (down) addr_next = addr_cur - stride;
    else           addr_next = addr_cur + stride;
  end
endmodule

// File: rtl/dmaseq_regs.sv
module dmaseq_regs
  import dmaseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic [2:0]        cpu_addr,
  input  logic [REG_W-1:0]  cpu_wdata,
  output logic [REG_W-1:0]  cpu_rdata,
  input  logic              xfer_done,
  input  logic [ADDR_W-1:0] src_next,
  output ctrl_t             ctrl_q,
  output logic              master_q,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic              irq_q
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             rd_ctrl, wr_ctrl, wr_src, wr_dst, wr_cnt, wr_master;
  logic             count_end;

  always_comb begin
    rd_ctrl   = cpu_sel && !cpu_wr && (cpu_addr == OFS_CTRL);
    wr_ctrl   = cpu_sel &&  cpu_wr && (cpu_addr == OFS_CTRL);
    wr_src    = cpu_sel &&  cpu_wr && (cpu_addr == OFS_SRC);
    wr_dst    = cpu_sel &&  cpu_wr && (cpu_addr == OFS_DST);
    wr_cnt    = cpu_sel &&  cpu_wr && (cpu_addr == OFS_CNT);
    wr_master = cpu_sel &&  cpu_wr && (cpu_addr == OFS_MASTER);
    count_end = xfer_done && (cnt_q == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      master_q <= 1'b0;
      src_q    <= '0;
      dst_q    <= '0;
      cnt_q    <= '0;
      armed_q  <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      // A read of control arms the run bit only when run is seen at 0.
      if (rd_ctrl) armed_q <= !ctrl_q.run;
      if (wr_ctrl) begin
        armed_q    <= 1'b0;
        ctrl_q     <= ctrl_t'(cpu_wdata[CTRL_W-1:0]);
        ctrl_q.run <= cpu_wdata[0] & armed_q;
      end
      if (wr_master) master_q <= cpu_wdata[0];
      if (wr_src)         src_q <= cpu_wdata[ADDR_W-1:0];
      else if (xfer_done) src_q <= src_next;
      if (wr_dst) dst_q <= cpu_wdata[ADDR_W-1:0];
      if (wr_cnt)         cnt_q <= cpu_wdata[CNT_W-1:0];
      else if (xfer_done) cnt_q <= cnt_q - 1'b1;
      // End of count wins over a simultaneous software write of run.
      if (count_end) ctrl_q.run <= 1'b0;
      if (count_end && ctrl_q.irq_en) irq_q <= 1'b1;
      else if (wr_ctrl)               irq_q <= 1'b0;
    end
  end

  always_comb begin
    cpu_rdata = '0;
    case (cpu_addr)
      OFS_CTRL:   cpu_rdata[CTRL_W-1:0] = ctrl_q;
      OFS_SRC:    cpu_rdata[ADDR_W-1:0] = src_q;
      OFS_DST:    cpu_rdata[ADDR_W-1:0] = dst_q;
      OFS_CNT:    cpu_rdata[CNT_W-1:0]  = cnt_q;
      OFS_MASTER: cpu_rdata[0]          = master_q;
      default:    cpu_rdata = '0;
    endcase
  end

  // R3
  run_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.run) |-> ($past(armed_q) && $past(wr_ctrl)));

  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !wr_cnt) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R9
  end_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_end |=> !ctrl_q.run);

  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> (!ctrl_q.run && $past(xfer_done)));
endmodule

// File: rtl/dmaseq_fsm.sv
module dmaseq_fsm
  import dmaseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_active,
  input  logic              auto_go,
  input  logic              wide,
  input  logic              dreq,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_valid,
  output logic              mem_write,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              xfer_done
);
  phase_t            ph_q;
  logic              pend_q;
  logic              start;
  logic [DATA_W-1:0] rd_fmt;

  always_comb begin
    start     = (ph_q == PH_IDLE) && chan_active && (auto_go || pend_q);
    xfer_done = (ph_q == PH_WRITE) && mem_ready;
    mem_valid = (ph_q != PH_IDLE);
    mem_write = (ph_q == PH_WRITE);
    rd_fmt    = mem_wide ? mem_rdata
                         : {{(DATA_W-BYTE_W){1'b0}}, mem_rdata[BYTE_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      pend_q    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_wide  <= 1'b0;
    end else begin
      // Pending request: one slot, dropped when the channel is off or in auto.
      pend_q <= chan_active && !auto_go && ((pend_q && !start) || dreq);
      case (ph_q)
        PH_IDLE: if (start) begin
          ph_q     <= PH_READ;
          mem_addr <= src_addr;
          mem_wide <= wide;
        end
        PH_READ: if (mem_ready) begin
          ph_q      <= PH_WRITE;
          mem_addr  <= dst_addr;
          mem_wdata <= rd_fmt;
        end
        PH_WRITE: if (mem_ready) ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // R6
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)
                                   && $stable(mem_wide) && $stable(mem_wdata)));

  // R6
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_write && mem_ready) |=> (mem_valid && mem_write));

  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> $past(chan_active));

  // R5
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq && chan_active && !auto_go && mem_valid) |=> pend_q);
endmodule

// File: rtl/dmaseq_top.sv
module dmaseq_top
  import dmaseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic [2:0]        cpu_addr,
  input  logic [REG_W-1:0]  cpu_wdata,
  output logic [REG_W-1:0]  cpu_rdata,
  input  logic              dreq,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              irq
);
  ctrl_t             ctrl;
  logic              master;
  logic [ADDR_W-1:0] src, dst, src_next;
  logic              xfer_done;
  logic              chan_active;

  assign chan_active = ctrl.run && master;

  dmaseq_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .xfer_done(xfer_done), .src_next(src_next),
    .ctrl_q(ctrl), .master_q(master), .src_q(src), .dst_q(dst), .irq_q(irq)
  );

  dmaseq_step #(.ADDR_W(ADDR_W)) u_step (
    .addr_cur(src), .wide(mem_wide), .step_en(ctrl.step_en), .down(ctrl.down),
    .addr_next(src_next)
  );

  dmaseq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .chan_active(chan_active), .auto_go(ctrl.auto_go), .wide(ctrl.wide), .dreq(dreq),
    .src_addr(src), .dst_addr(dst),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_wide(mem_wide),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .xfer_done(xfer_done)
  );
endmodule

// File: tb/dmaseq_top_bench.sv
module dmaseq_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;
  localparam int REG_W  = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cpu_sel = 1'b0, cpu_wr = 1'b0;
  logic [2:0]        cpu_addr = '0;
  logic [REG_W-1:0]  cpu_wdata = '0;
  logic [REG_W-1:0]  cpu_rdata;
  logic              dreq = 1'b0;
  logic              mem_valid, mem_write, mem_wide, irq;
  logic              mem_ready = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata = '0;

  int checks = 0, errors = 0, valid_seen = 0, rmode = 0;
  logic [7:0] tick = '0;

  dmaseq_top u_dmaseq_top (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .dreq(dreq),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model state
  logic m_run, m_wide, m_step, m_down, m_irqen, m_auto, m_master, m_armed, m_irq, m_pend, m_xwide;
  logic [ADDR_W-1:0] m_src, m_dst, m_addr;
  logic [15:0]       m_cnt;
  logic [DATA_W-1:0] m_data;
  int                m_ph;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic act, st, dn, fin, irq_set, rdc, wrc;
    logic [ADDR_W-1:0] stride, nsrc;
    if (!rst_n) begin
      {m_run, m_wide, m_step, m_down, m_irqen, m_auto, m_master, m_armed, m_irq, m_pend, m_xwide} = '0;
      m_src = '0; m_dst = '0; m_addr = '0; m_cnt = '0; m_data = '0; m_ph = 0;
      return;
    end
    act     = m_run && m_master;
    st      = (m_ph == 0) && act && (m_auto || m_pend);
    dn      = (m_ph == 2) && mem_ready;
    fin     = dn && (m_cnt == 16'd1);
    irq_set = fin && m_irqen;
    rdc     = cpu_sel && !cpu_wr && (cpu_addr == 3'd0);
    wrc     = cpu_sel &&  cpu_wr && (cpu_addr == 3'd0);
    stride  = m_xwide ? 24'd2 : 24'd1;
    nsrc    = !m_step ? m_src : (m_down ? m_src - stride : m_src + stride);
    m_pend  = act && !m_auto && ((m_pend && !st) || dreq);
    if (m_ph == 0) begin
      if (st) begin m_ph = 1; m_addr = m_src; m_xwide = m_wide; end
    end else if (m_ph == 1) begin
      if (mem_ready) begin
        m_ph = 2; m_addr = m_dst;
        m_data = m_xwide ? mem_rdata : {8'h00, mem_rdata[7:0]};
      end
    end else if (mem_ready) m_ph = 0;
    if (rdc) m_armed = !m_run;
    if (wrc) begin
      m_run = cpu_wdata[0] & m_armed; m_armed = 1'b0;
      m_wide = cpu_wdata[1]; m_step = cpu_wdata[2]; m_down = cpu_wdata[3];
      m_irqen = cpu_wdata[4]; m_auto = cpu_wdata[5];
    end
    if (cpu_sel && cpu_wr && cpu_addr == 3'd4) m_master = cpu_wdata[0];
    if (cpu_sel && cpu_wr && cpu_addr == 3'd1) m_src = cpu_wdata[ADDR_W-1:0];
    else if (dn) m_src = nsrc;
    if (cpu_sel && cpu_wr && cpu_addr == 3'd2) m_dst = cpu_wdata[ADDR_W-1:0];
    if (cpu_sel && cpu_wr && cpu_addr == 3'd3) m_cnt = cpu_wdata[15:0];
    else if (dn) m_cnt = m_cnt - 16'd1;
    if (fin) m_run = 1'b0;
    if (irq_set) m_irq = 1'b1;
    else if (wrc) m_irq = 1'b0;
  endtask

  function automatic logic [31:0] model_rdata();
    case (cpu_addr)
      3'd0: return {26'd0, m_auto, m_irqen, m_down, m_step, m_wide, m_run};
      3'd1: return {8'd0, m_src};
      3'd2: return {8'd0, m_dst};
      3'd3: return {16'd0, m_cnt};
      3'd4: return {31'd0, m_master};
      default: return 32'd0;
    endcase
  endfunction

  // Update the model at each edge, compare a quarter period later.
  always @(posedge clk) begin
    model_step();
    #(CLK_PERIOD/4);
    check(mem_valid === (m_ph != 0), "R6", {31'd0, mem_valid}, {31'd0, m_ph != 0});
    check(mem_write === (m_ph == 2), "R6", {31'd0, mem_write}, {31'd0, m_ph == 2});
    if (m_ph != 0) begin
      check(mem_addr === m_addr, "R8", {8'd0, mem_addr}, {8'd0, m_addr});
      check(mem_wide === m_xwide, "R7", {31'd0, mem_wide}, {31'd0, m_xwide});
    end
    if (m_ph == 2) check(mem_wdata === m_data, "R7", {16'd0, mem_wdata}, {16'd0, m_data});
    check(irq === m_irq, "R10", {31'd0, irq}, {31'd0, m_irq});
    check(cpu_rdata === model_rdata(), "R11", cpu_rdata, model_rdata());
    if (mem_valid === 1'b1) valid_seen++;
  end

  // Memory responder
  always @(negedge clk) begin
    tick <= tick + 8'd1;
    mem_ready <= (rmode == 0) ? 1'b1 : (rmode == 1) ? (tick[1:0] == 2'b11) : 1'b0;
    mem_rdata <= DATA_W'(mem_addr[15:0] * 16'd3 + 16'h1357);
  end

  task automatic cpu_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_sel = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_addr = a;
    #1 d = cpu_rdata;
    @(negedge clk); cpu_sel = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int v1;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);

    // R1 reset state
    cpu_read(3'd0, rd); check(rd == 32'h0, "R1", rd, 32'h0);
    cpu_read(3'd4, rd); check(rd == 32'h0, "R1", rd, 32'h0);
    check(irq === 1'b0 && mem_valid === 1'b0, "R1", {30'd0, irq, mem_valid}, 32'h0);

    // R3 guarded run bit
    cpu_write(3'd0, 32'h00);
    cpu_write(3'd0, 32'h01);
    cpu_read(3'd0, rd); check(rd == 32'h00, "R3", rd, 32'h00);
    cpu_write(3'd3, 32'd1);
    cpu_write(3'd1, 32'h40);
    cpu_write(3'd2, 32'h80);
    cpu_read(3'd0, rd);
    cpu_write(3'd0, 32'h01);
    cpu_read(3'd0, rd); check(rd == 32'h01, "R3", rd, 32'h01);

    // R2 master off: request ignored and not remembered
    rmode = 0;
    valid_seen = 0;
    pulse_req(); wait_cyc(5);
    check(valid_seen == 0, "R2", valid_seen, 0);
    cpu_write(3'd4, 32'h1); wait_cyc(5);
    check(valid_seen == 0, "R2", valid_seen, 0);
    // R4 request mode: one pulse gives one transfer (two beats)
    pulse_req(); wait_cyc(10);
    check(valid_seen == 2, "R4", valid_seen, 2);
    cpu_read(3'd0, rd); check(rd == 32'h00, "R9", rd, 32'h00);

    // R5 merged requests while bus stalls; word increment with interrupt
    cpu_write(3'd1, 32'h100);
    cpu_write(3'd2, 32'h800);
    cpu_write(3'd3, 32'd4);
    cpu_read(3'd0, rd);
    cpu_write(3'd0, 32'h17);
    rmode = 2;
    pulse_req(); wait_cyc(4);
    check(mem_valid === 1'b1, "R4", {31'd0, mem_valid}, 32'h1);
    pulse_req(); pulse_req();
    rmode = 0; wait_cyc(30);
    cpu_read(3'd1, rd); check(rd == 32'h104, "R5", rd, 32'h104);
    cpu_read(3'd3, rd); check(rd == 32'd2, "R5", rd, 32'd2);
    pulse_req(); wait_cyc(10);
    pulse_req(); wait_cyc(10);
    cpu_read(3'd0, rd); check(rd == 32'h16, "R9", rd, 32'h16);
    check(irq === 1'b1, "R10", {31'd0, irq}, 32'h1);
    cpu_read(3'd1, rd); check(rd == 32'h108, "R8", rd, 32'h108);
    cpu_write(3'd0, 32'h16); wait_cyc(1);
    check(irq === 1'b0, "R10", {31'd0, irq}, 32'h0);

    // R7/R8 auto byte decrement under slow bus, no interrupt
    rmode = 1;
    cpu_write(3'd1, 32'h50);
    cpu_write(3'd2, 32'h900);
    cpu_write(3'd3, 32'd3);
    cpu_read(3'd0, rd);
    cpu_write(3'd0, 32'h2D);
    wait_cyc(80);
    cpu_read(3'd1, rd); check(rd == 32'h4D, "R8", rd, 32'h4D);
    cpu_read(3'd2, rd); check(rd == 32'h900, "R8", rd, 32'h900);
    cpu_read(3'd0, rd); check(rd == 32'h2C, "R9", rd, 32'h2C);
    check(irq === 1'b0, "R10", {31'd0, irq}, 32'h0);

    // R8 fixed source, word
    rmode = 0;
    cpu_write(3'd1, 32'h200);
    cpu_write(3'd3, 32'd2);
    cpu_read(3'd0, rd);
    cpu_write(3'd0, 32'h2B);
    wait_cyc(20);
    cpu_read(3'd1, rd); check(rd == 32'h200, "R8", rd, 32'h200);
    cpu_read(3'd3, rd); check(rd == 32'd0, "R9", rd, 32'd0);

    // R2 clearing master stops an auto run
    cpu_write(3'd1, 32'h1000);
    cpu_write(3'd3, 32'd1000);
    cpu_read(3'd0, rd);
    cpu_write(3'd0, 32'h27);
    wait_cyc(10);
    cpu_write(3'd4, 32'h0);
    wait_cyc(10);
    v1 = valid_seen;
    wait_cyc(20);
    check(valid_seen == v1, "R2", valid_seen, v1);
    cpu_read(3'd3, rd); check(rd != 32'd1000 && rd != 32'd0, "R4", rd, 32'd1000);

    wait_cyc(2);
    finish_run();
  end
endmodule